// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block sits next to an instruction fetch unit and runs hardware repeat loops without any branch instructions. A repeat command hands it a first-instruction address, a last-instruction address and an iteration count. From then on the block watches every fetch address. When the fetch reaches the last address of the body and more than one pass remains, the block tells the fetch unit to go back to the first address, and it lowers the remaining count by one.

Bodies of one, two, three or more instructions all work. A one-instruction body has the same first and last address. The block records the body-length class in a 2-bit flag field. That field sits next to the 12-bit remaining count in a status register. The first address, the last address and the status register can all be read and written through a small register port. Exception software can therefore save the loop state, clear it, and later put it back so that the loop resumes exactly where it stopped.

Addresses are in instruction units. Without a redirect, the fetch unit advances to the current address plus one.

Top module: `rptLoopUnit`

## Requirements
- R1: After reset the first-address, last-address and status registers all read 0, and no redirect is raised.
- R2: A repeat command (rptLoad) with a nonzero count latches the first address, the last address and the count. It sets the flag to 01 when the last address equals the first, to 10 when it is one above the first, and to 11 otherwise. The status register reads the count in bits [11:0] and the flag in bits [13:12], with zeros above.
- R3: A repeat command with a count of 0 leaves the flag and count at 0. The body then runs once and no redirect occurs.
- R4: In a cycle where fetchValid is high, fetchPc equals the last address, the flag is nonzero and the count is above 1, redirect is high in that same cycle, redirectPc equals the first address, and the count is one lower in the next cycle.
- R5: When the last address is fetched with a count of 1, redirect stays low and both the count and the flag become 0.
- R6: While the flag reads 00, fetching the last address raises no redirect.
- R7: A one-instruction loop with count N fetches its single address N times and then falls through.
- R8: Loops of two, three and more instructions each fetch the full body N times in address order and then fall through to the last address plus one.
- R9: Register select 0 accesses the first address, select 1 the last address and select 2 the status register. Writing back saved values resumes an interrupted loop with the same remaining passes.
- R10: A status write in the same cycle as a hardware decrement wins: the written count and flag are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch is being issued this cycle |
| fetchPc | input | ADDR_W | Address being fetched |
| redirect | output | 1 | Next fetch must go to redirectPc |
| redirectPc | output | ADDR_W | Loop first address |
| rptLoad | input | 1 | Repeat command strobe |
| rptStart | input | ADDR_W | First address of the body |
| rptEnd | input | ADDR_W | Last address of the body |
| rptCount | input | 12 | Requested pass count |
| regWrEn | input | 1 | Register port write strobe |
| regSel | input | 2 | Register select |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for regSel |

## Verification
The hardware decrement at the last address and a software write to the status register can land in the same cycle. The bench provokes this by walking a loop up to its last address and, at that fetch, also driving a status write with a count that differs from both the old count and the decremented one. It then reads the status register back and expects the written value. It also expects redirect to stay high in that cycle, because the redirect decision uses the count held before the write.

// File: rtl/rptLoopPkg.sv
package rptLoopPkg;
  localparam int CNT_W = 12;
  localparam int FLAG_LSB = 12;

  typedef enum logic [1:0] {
    LEN_NONE = 2'b00,
    LEN_ONE  = 2'b01,
    LEN_TWO  = 2'b10,
    LEN_MANY = 2'b11
  } loopLen_e;

  localparam logic [1:0] SEL_START  = 2'd0;
  localparam logic [1:0] SEL_END    = 2'd1;
  localparam logic [1:0] SEL_STATUS = 2'd2;

  typedef struct packed {
    logic loadCmd;
    logic decCount;
    logic finish;
    logic wrStart;
    logic wrEnd;
    logic wrStatus;
  } strobes_t;
endpackage

// File: rtl/rptCtrl.sv
module rptCtrl
  import rptLoopPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              rptLoad,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [CNT_W-1:0]  count,
  input  loopLen_e          flag,
  output strobes_t          strb,
  output logic              redirect
);
  logic atEnd;
  logic moreLeft;
  logic lastPass;

  always_comb begin
    atEnd    = fetchValid && (fetchPc == endAddr) && (flag != LEN_NONE);
    moreLeft = count > CNT_W'(1);
    lastPass = count == CNT_W'(1);
    redirect = atEnd && moreLeft;

    strb          = '0;
    strb.loadCmd  = rptLoad;
    strb.decCount = atEnd && moreLeft;
    strb.finish   = atEnd && lastPass;
    strb.wrStart  = regWrEn && (regSel == SEL_START);
    strb.wrEnd    = regWrEn && (regSel == SEL_END);
    strb.wrStatus = regWrEn && (regSel == SEL_STATUS);
  end

  // R4 R5
  onehot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.decCount, strb.finish}));

  // R6
  idle_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag == LEN_NONE) |-> !redirect);
endmodule

// File: rtl/rptData.sv
module rptData
  import rptLoopPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] cmdStart,
  input  logic [ADDR_W-1:0] cmdEnd,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] startQ,
  output logic [ADDR_W-1:0] endQ,
  output logic [CNT_W-1:0]  countQ,
  output loopLen_e          flagQ,
  output logic [DATA_W-1:0] rdData
);
  localparam int STAT_W = FLAG_LSB + 2;

  logic [ADDR_W-1:0] span;
  loopLen_e          cmdClass;
  logic [STAT_W-1:0] statusWord;

  always_comb begin
    span = cmdEnd - cmdStart;
    if (span == '0)               cmdClass = LEN_ONE;
    else if (span == ADDR_W'(1))  cmdClass = LEN_TWO;
    else                          cmdClass = LEN_MANY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startQ <= '0;
      endQ   <= '0;
      countQ <= '0;
      flagQ  <= LEN_NONE;
    end else if (strb.loadCmd) begin
      startQ <= cmdStart;
      endQ   <= cmdEnd;
      if (cmdCount == '0) begin
        countQ <= '0;
        flagQ  <= LEN_NONE;
      end else begin
        countQ <= cmdCount;
        flagQ  <= cmdClass;
      end
    end else begin
      if (strb.wrStart) startQ <= wrData[ADDR_W-1:0];
      if (strb.wrEnd)   endQ   <= wrData[ADDR_W-1:0];
      if (strb.wrStatus) begin
        countQ <= wrData[CNT_W-1:0];
        flagQ  <= loopLen_e'(wrData[FLAG_LSB+1:FLAG_LSB]);
      end else if (strb.decCount) begin
        countQ <= countQ - CNT_W'(1);
      end else if (strb.finish) begin
        countQ <= '0;
        flagQ  <= LEN_NONE;
      end
    end
  end

  always_comb begin
    statusWord = {flagQ, countQ};
    case (regSel)
      SEL_START:  rdData = DATA_W'(startQ);
      SEL_END:    rdData = DATA_W'(endQ);
      SEL_STATUS: rdData = DATA_W'(statusWord);
      default:    rdData = '0;
    endcase
  end

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.decCount && !strb.loadCmd && !strb.wrStatus) |=> countQ == $past(countQ) - CNT_W'(1));

  // R5
  last_pass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.finish && !strb.loadCmd && !strb.wrStatus) |=> (countQ == '0 && flagQ == LEN_NONE));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrStatus && !strb.loadCmd) |=> countQ == $past(wrData[CNT_W-1:0]));

  // R3
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadCmd && cmdCount == '0) |=> flagQ == LEN_NONE);

  // R6
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagQ == LEN_NONE && !strb.loadCmd && !strb.wrStatus) |=> flagQ == LEN_NONE);
endmodule

// File: rtl/rptLoopUnit.sv
module rptLoopUnit
  import rptLoopPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectPc,
  input  logic              rptLoad,
  input  logic [ADDR_W-1:0] rptStart,
  input  logic [ADDR_W-1:0] rptEnd,
  input  logic [11:0]       rptCount,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  strobes_t          strb;
  logic [ADDR_W-1:0] startQ;
  logic [ADDR_W-1:0] endQ;
  logic [CNT_W-1:0]  countQ;
  loopLen_e          flagQ;

  initial begin
    if (DATA_W < FLAG_LSB + 2 || DATA_W < ADDR_W)
      $error("DATA_W too narrow for status or address");
  end

  rptCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetchValid(fetchValid), .fetchPc(fetchPc),
    .rptLoad(rptLoad), .regWrEn(regWrEn), .regSel(regSel),
    .endAddr(endQ), .count(countQ), .flag(flagQ),
    .strb(strb), .redirect(redirect)
  );

  rptData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .cmdStart(rptStart), .cmdEnd(rptEnd), .cmdCount(rptCount),
    .regSel(regSel), .wrData(regWrData),
    .startQ(startQ), .endQ(endQ), .countQ(countQ), .flagQ(flagQ),
    .rdData(regRdData)
  );

  assign redirectPc = startQ;
endmodule

// File: tb/rptLoopUnit_test.sv
`timescale 1ns/1ps
module rptLoopUnit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchPc = '0;
  logic        redirect;
  logic [15:0] redirectPc;
  logic        rptLoad = 1'b0;
  logic [15:0] rptStart = '0;
  logic [15:0] rptEnd = '0;
  logic [11:0] rptCount = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rptLoopUnit uut (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .redirect(redirect), .redirectPc(redirectPc),
    .rptLoad(rptLoad), .rptStart(rptStart), .rptEnd(rptEnd), .rptCount(rptCount),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [15:0] statWord(input logic [1:0] f, input logic [11:0] c);
    return {2'b00, f, c};
  endfunction

  function automatic logic [1:0] lenClass(input int len, input int n);
    if (n == 0) return 2'b00;
    if (len == 1) return 2'b01;
    if (len == 2) return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    regSel = sel;
    #1 val = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(posedge clk); #1 regWrEn = 1'b0;
  endtask

  task automatic loadCmd(input logic [15:0] s, input logic [15:0] e, input logic [11:0] n);
    @(negedge clk);
    rptLoad = 1'b1; rptStart = s; rptEnd = e; rptCount = n;
    @(posedge clk); #1 rptLoad = 1'b0;
  endtask

  // One fetch cycle against the bench model; returns the next address.
  task automatic stepFetch(inout logic [15:0] pc, inout int mCount, inout bit mActive,
                           input logic [15:0] s, input logic [15:0] e, inout int ends,
                           input string req);
    bit expRed;
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = pc;
    #1;
    expRed = mActive && (pc == e) && (mCount > 1);
    check(redirect == expRed, req, 32'(redirect), 32'(expRed));
    if (expRed) check(redirectPc == s, "R4 target", 32'(redirectPc), 32'(s));
    if (pc == e) begin
      ends++;
      if (mActive) begin
        if (mCount > 1) mCount--;
        else begin mCount = 0; mActive = 0; end
      end
    end
    pc = expRed ? s : pc + 16'd1;
  endtask

  task automatic runLoop(input logic [15:0] s, input int len, input int n, input string req);
    logic [15:0] e;
    logic [15:0] pc;
    logic [15:0] v;
    int mCount;
    bit mActive;
    int ends;
    int guard;
    e = s + 16'(len - 1);
    loadCmd(s, e, 12'(n));
    readReg(2'd2, v);
    check(v == statWord(lenClass(len, n), 12'(n)), "R2 status after load", 32'(v),
          32'(statWord(lenClass(len, n), 12'(n))));
    mCount = n; mActive = (n != 0); ends = 0; guard = 0; pc = s;
    while (pc != e + 16'd1 && guard < 20000) begin
      stepFetch(pc, mCount, mActive, s, e, ends, req);
      guard++;
    end
    @(negedge clk); fetchValid = 1'b0;
    check(ends == ((n == 0) ? 1 : n), req, 32'(ends), 32'((n == 0) ? 1 : n));
    readReg(2'd2, v);
    check(v == 16'd0, "R5 status cleared at exit", 32'(v), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] pc;
    logic [15:0] sv0, sv1, sv2;
    int mCount;
    bit mActive;
    int ends;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    readReg(2'd0, v); check(v == 0, "R1 start", 32'(v), 0);
    readReg(2'd1, v); check(v == 0, "R1 end", 32'(v), 0);
    readReg(2'd2, v); check(v == 0, "R1 status", 32'(v), 0);
    @(negedge clk); fetchValid = 1'b1; fetchPc = 16'd0; #1;
    check(redirect == 1'b0, "R1 no redirect", 32'(redirect), 0);
    @(negedge clk); fetchValid = 1'b0;

    // R7 one instruction, R8 two, three, five
    runLoop(16'd40, 1, 4, "R7 one-instr loop");
    runLoop(16'd60, 2, 4, "R8 two-instr loop");
    runLoop(16'd80, 3, 4, "R8 three-instr loop");
    runLoop(16'd100, 5, 7, "R8 five-instr loop");
    // R5 single pass, R3 zero count
    runLoop(16'd120, 3, 1, "R5 count one");
    runLoop(16'd140, 2, 0, "R3 zero count");

    // R9 register port access
    writeReg(2'd0, 16'h1234); readReg(2'd0, v); check(v == 16'h1234, "R9 start rw", 32'(v), 32'h1234);
    writeReg(2'd1, 16'h0abc); readReg(2'd1, v); check(v == 16'h0abc, "R9 end rw", 32'(v), 32'h0abc);
    writeReg(2'd2, 16'h0000);

    // R9 save, clear, restore in the middle of a loop
    loadCmd(16'd200, 16'd202, 12'd6);
    mCount = 6; mActive = 1; ends = 0; pc = 16'd200;
    while (!(ends == 2 && pc == 16'd201))
      stepFetch(pc, mCount, mActive, 16'd200, 16'd202, ends, "R9 before save");
    @(negedge clk); fetchValid = 1'b0;
    readReg(2'd0, sv0); readReg(2'd1, sv1); readReg(2'd2, sv2);
    check(sv2 == statWord(2'b11, 12'd4), "R9 saved status", 32'(sv2), 32'(statWord(2'b11, 12'd4)));
    writeReg(2'd2, 16'h0000);
    // R6 cleared flag ignores the last address
    @(negedge clk); fetchValid = 1'b1; fetchPc = 16'd202; #1;
    check(redirect == 1'b0, "R6 no redirect when idle", 32'(redirect), 0);
    @(negedge clk); fetchValid = 1'b0;
    readReg(2'd2, v); check(v == 16'd0, "R6 status still idle", 32'(v), 0);
    writeReg(2'd0, sv0); writeReg(2'd1, sv1); writeReg(2'd2, sv2);
    while (pc != 16'd203)
      stepFetch(pc, mCount, mActive, 16'd200, 16'd202, ends, "R9 after restore");
    @(negedge clk); fetchValid = 1'b0;
    check(ends == 6, "R9 resumed pass total", 32'(ends), 6);

    // R10 status write same cycle as decrement
    loadCmd(16'd300, 16'd304, 12'd5);
    for (int a = 300; a < 304; a++) begin
      @(negedge clk); fetchValid = 1'b1; fetchPc = 16'(a);
    end
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = 16'd304;
    regWrEn = 1'b1; regSel = 2'd2; regWrData = statWord(2'b11, 12'd9);
    #1 check(redirect == 1'b1, "R10 redirect uses old count", 32'(redirect), 1);
    @(posedge clk); #1 regWrEn = 1'b0; fetchValid = 1'b0;
    readReg(2'd2, v);
    check(v == statWord(2'b11, 12'd9), "R10 write wins", 32'(v), 32'(statWord(2'b11, 12'd9)));
    writeReg(2'd2, 16'h0000);

    // Random loops with fixed seed
    for (int k = 0; k < 20; k++) begin
      int len;
      int n;
      logic [15:0] s;
      len = 1 + int'($urandom % 6);
      n   = int'($urandom % 12);
      s   = 16'(400 + ($urandom % 1000));
      runLoop(s, len, n, (len == 1) ? "R7 random" : "R8 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule